// File: doc/BRIEF.md
# Serial Controller Interrupt Event Generator

This block builds the second-level interrupt request of a serial controller working as an SPI slave. It watches three FIFO status flags (transmit idle, transmit has room, receive holds data), the busy flags of four DMA buffers (transmit A/B, receive A/B) and two one-cycle error strobes (receive overrun, transmit underrun). It records each event in a pending register and forms one request line from the pending bits that software has enabled.

Each of the three FIFO status sources can be programmed to trigger in one of two ways. In edge mode a 0-to-1 change of the flag latches a sticky pending bit. In level mode the pending bit simply mirrors the flag. A DMA buffer counts as finished when its busy flag drops from 1 to 0. Sticky bits are cleared by writing ones to the clear input. Pending bits are recorded whether or not their source is enabled, so enabling a source that is already pending raises the request at once. The final request also needs the controller-level enable.

Top module: `sc_irq_evgen`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous), all pending bits read 0 and irq is 0, whatever the enables are.
- R2: Pending index map: bits [2:0] are transmit idle, transmit free and receive valid (stat_flags[2:0]). Bits [6:3] are DMA transmit A, transmit B, receive A and receive B complete (dma_active[3:0]). Bit 7 is receive overrun (err_pulse[0]) and bit 8 is transmit underrun (err_pulse[1]).
- R3: For a status source whose lvl_mode bit is 0, a 0-to-1 change of the flag between two clock edges sets its pending bit one clock later. The bit stays set after the flag falls. A flag that stays high does not set the bit again after it has been cleared.
- R4: For a status source whose lvl_mode bit is 1, the pending bit equals the flag as sampled at the previous clock edge, and pend_clr has no effect on it.
- R5: A 1-to-0 change of a dma_active bit sets the matching pending bit one clock later. A 0-to-1 change sets nothing.
- R6: A high err_pulse bit at a clock edge sets the matching pending bit, which stays set until it is cleared.
- R7: A 1 in pend_clr clears the matching sticky pending bit at the next edge. A 0 in pend_clr leaves its bit unchanged.
- R8: If a new event and a clear for the same bit arrive at the same edge, the bit ends up set.
- R9: Pending bits are recorded regardless of int_enable. irq follows changes in int_enable and top_enable in the same cycle, with no clock edge needed, and is 1 exactly when some pending bit is enabled and top_enable is 1.
- R10: With top_enable at 0, irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_flags | input | 3 | Live FIFO status flags: transmit idle, transmit free, receive valid |
| lvl_mode | input | 3 | Per status source: 1 = level trigger, 0 = rising-edge trigger |
| dma_active | input | 4 | DMA buffer busy flags: TX A, TX B, RX A, RX B |
| err_pulse | input | 2 | One-cycle error strobes: receive overrun, transmit underrun |
| int_enable | input | 9 | Second-level enable, one bit per pending bit |
| pend_clr | input | 9 | Write-one-to-clear strobe for the sticky pending bits |
| top_enable | input | 1 | Controller-level interrupt enable |
| pending | output | 9 | Raw pending flags |
| irq | output | 1 | Combined interrupt request |

## Verification
Every pending result is due one clock edge after its stimulus. The flag, strobe or clear is applied one time unit after an edge, and pending is read one time unit after the next edge. The edge detectors compare against the value held from the previous edge, so a transition driven before an edge latches at that edge. irq depends on pending and on the two enables through logic alone, so changes to the enables are checked a few time units later with no clock edge in between. This shows that a source which is already pending raises the request as soon as it is enabled.

// File: rtl/sc_irq_pkg.sv
package sc_irq_pkg;
   // How a source turns its input into a set strobe
   typedef enum logic [1:0] {
      TRIG_RISE  = 2'd0,
      TRIG_FALL  = 2'd1,
      TRIG_PULSE = 2'd2
   } trig_e;

   localparam int unsigned DEF_STAT_W = 3;
   localparam int unsigned DEF_DMA_W  = 4;
   localparam int unsigned DEF_ERR_W  = 2;
endpackage

// File: rtl/sc_irq_edge.sv
module sc_irq_edge #(
   parameter int unsigned        W    = 1,
   parameter sc_irq_pkg::trig_e  KIND = sc_irq_pkg::TRIG_RISE
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] sig,
   output logic [W-1:0] evt
);
   generate
      if (KIND == sc_irq_pkg::TRIG_PULSE) begin : g_pulse
         assign evt = sig;
      end else begin : g_trans
         logic [W-1:0] prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= '0;
            else        prev_q <= sig;
         end
         if (KIND == sc_irq_pkg::TRIG_RISE) begin : g_rise
            assign evt = sig & ~prev_q;
         end else begin : g_fall
            assign evt = ~sig & prev_q;
         end
      end
   endgenerate
endmodule

// File: rtl/sc_irq_pend.sv
module sc_irq_pend #(
   parameter int unsigned W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_evt,
   input  logic [W-1:0] lvl_sel,
   input  logic [W-1:0] lvl_val,
   input  logic [W-1:0] clr,
   output logic [W-1:0] pend
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          bit_q <= 1'b0;
         else if (lvl_sel[i]) bit_q <= lvl_val[i];
         else                 bit_q <= (bit_q & ~clr[i]) | set_evt[i];
      end
      assign pend[i] = bit_q;
   end
endmodule

// File: rtl/sc_irq_evgen.sv
module sc_irq_evgen #(
   parameter int unsigned STAT_W = sc_irq_pkg::DEF_STAT_W,
   parameter int unsigned DMA_W  = sc_irq_pkg::DEF_DMA_W,
   parameter int unsigned ERR_W  = sc_irq_pkg::DEF_ERR_W,
   localparam int unsigned NSRC  = STAT_W + DMA_W + ERR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] stat_flags,
   input  logic [STAT_W-1:0] lvl_mode,
   input  logic [DMA_W-1:0]  dma_active,
   input  logic [ERR_W-1:0]  err_pulse,
   input  logic [NSRC-1:0]   int_enable,
   input  logic [NSRC-1:0]   pend_clr,
   input  logic              top_enable,
   output logic [NSRC-1:0]   pending,
   output logic              irq
);
   localparam int unsigned NOLVL = DMA_W + ERR_W;

   generate
      if (STAT_W < 1 || DMA_W < 1 || ERR_W < 1) begin : g_bad_width
         $error("sc_irq_evgen: every source group needs at least one member");
      end
   endgenerate

   logic [STAT_W-1:0] stat_evt;
   logic [DMA_W-1:0]  dma_evt;
   logic [ERR_W-1:0]  err_evt;

   sc_irq_edge #(.W(STAT_W), .KIND(sc_irq_pkg::TRIG_RISE)) u_stat_edge (
      .clk(clk), .rst_n(rst_n), .sig(stat_flags), .evt(stat_evt));

   sc_irq_edge #(.W(DMA_W), .KIND(sc_irq_pkg::TRIG_FALL)) u_dma_edge (
      .clk(clk), .rst_n(rst_n), .sig(dma_active), .evt(dma_evt));

   sc_irq_edge #(.W(ERR_W), .KIND(sc_irq_pkg::TRIG_PULSE)) u_err_edge (
      .clk(clk), .rst_n(rst_n), .sig(err_pulse), .evt(err_evt));

   logic [NSRC-1:0] evt_all;
   logic [NSRC-1:0] lvl_sel_all;
   logic [NSRC-1:0] lvl_val_all;

   assign evt_all     = {err_evt, dma_evt, stat_evt};
   assign lvl_sel_all = {{NOLVL{1'b0}}, lvl_mode};
   assign lvl_val_all = {{NOLVL{1'b0}}, stat_flags};

   sc_irq_pend #(.W(NSRC)) u_pend (
      .clk(clk), .rst_n(rst_n),
      .set_evt(evt_all), .lvl_sel(lvl_sel_all), .lvl_val(lvl_val_all),
      .clr(pend_clr), .pend(pending));

   assign irq = top_enable & (|(pending & int_enable));
endmodule

// File: rtl/sc_irq_evgen_chk.sv
module sc_irq_evgen_chk #(
   parameter int unsigned STAT_W = 3,
   parameter int unsigned DMA_W  = 4,
   parameter int unsigned ERR_W  = 2,
   localparam int unsigned NSRC  = STAT_W + DMA_W + ERR_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [STAT_W-1:0] stat_flags,
   input logic [STAT_W-1:0] lvl_mode,
   input logic [DMA_W-1:0]  dma_active,
   input logic [ERR_W-1:0]  err_pulse,
   input logic [NSRC-1:0]   int_enable,
   input logic [NSRC-1:0]   pend_clr,
   input logic              top_enable,
   input logic [NSRC-1:0]   pending,
   input logic              irq
);
   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         a_r1_reset_quiet: assert (pending == '0 && !irq)
            else $error("R1: outputs active in reset");
      end
   end

   for (genvar i = 0; i < STAT_W; i++) begin : g_stat
      a_r4_level_follow: assert property (@(posedge clk) disable iff (!rst_n || !armed)
         $past(lvl_mode[i]) |-> pending[i] == $past(stat_flags[i]));
      a_r7_stat_hold: assert property (@(posedge clk) disable iff (!rst_n || !armed)
         ($past(pending[i]) && !$past(pend_clr[i]) && !$past(lvl_mode[i])) |-> pending[i]);
   end

   for (genvar i = 0; i < DMA_W; i++) begin : g_dma
      a_r5_dma_fall: assert property (@(posedge clk) disable iff (!rst_n || !armed)
         $fell(dma_active[i]) |=> pending[STAT_W+i]);
   end

   for (genvar i = 0; i < ERR_W; i++) begin : g_err
      a_r8_err_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         err_pulse[i] |=> pending[STAT_W+DMA_W+i]);
   end

   for (genvar i = STAT_W; i < NSRC; i++) begin : g_hold
      a_r7_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n || !armed)
         ($past(pending[i]) && !$past(pend_clr[i])) |-> pending[i]);
   end

   a_r9_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (|(pending & int_enable)));

   a_r10_top_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !top_enable |-> !irq);
endmodule

bind sc_irq_evgen sc_irq_evgen_chk #(.STAT_W(STAT_W), .DMA_W(DMA_W), .ERR_W(ERR_W)) u_chk (.*);

// File: tb/sc_irq_evgen_bench.sv
`timescale 1ns/1ps
module sc_irq_evgen_bench;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [2:0] stat_flags, lvl_mode;
   logic [3:0] dma_active;
   logic [1:0] err_pulse;
   logic [8:0] int_enable, pend_clr, pending;
   logic       top_enable, irq;
   int         n_vec = 0;
   int         n_bad = 0;
   bit         done  = 1'b0;

   always #10 clk = ~clk;

   sc_irq_evgen u_sc_irq_evgen (
      .clk(clk), .rst_n(rst_n), .stat_flags(stat_flags), .lvl_mode(lvl_mode),
      .dma_active(dma_active), .err_pulse(err_pulse), .int_enable(int_enable),
      .pend_clr(pend_clr), .top_enable(top_enable), .pending(pending), .irq(irq));

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0; stat_flags = '0; lvl_mode = '0; dma_active = '0;
      err_pulse = '0; int_enable = '1; pend_clr = '0; top_enable = 1'b1;
      repeat (3) tick();
      chk("R1 pending in reset", pending, 9'h000);
      chk("R1 irq in reset", {8'h0, irq}, 9'h000);
      rst_n = 1'b1;
      tick();
      chk("R1 after release", pending, 9'h000);
   endtask

   task automatic t_edge_status();
      stat_flags = 3'b001; tick();
      chk("R3 rise sets bit0", pending, 9'h001);
      chk("R9 irq on enabled bit", {8'h0, irq}, 9'h001);
      stat_flags = 3'b000; tick();
      chk("R3 sticky after fall", pending, 9'h001);
      pend_clr = 9'h001; tick(); pend_clr = '0;
      chk("R7 w1c clears bit0", pending, 9'h000);
      stat_flags = 3'b010; pend_clr = 9'h002; tick(); pend_clr = '0;
      chk("R8 set beats clear", pending, 9'h002);
      pend_clr = 9'h002; tick(); pend_clr = '0;
      tick();
      chk("R3 held-high flag no retrigger", pending, 9'h000);
      stat_flags = 3'b001; tick();
      pend_clr = 9'h004; tick(); pend_clr = '0;
      chk("R7 zero clear bits ignored", pending, 9'h001);
      stat_flags = 3'b000; pend_clr = 9'h001; tick(); pend_clr = '0;
      chk("R7 cleanup", pending, 9'h000);
   endtask

   task automatic t_level_status();
      lvl_mode = 3'b100; stat_flags = 3'b100; tick();
      chk("R4 level follows flag high", pending, 9'h004);
      pend_clr = 9'h004; tick(); pend_clr = '0;
      chk("R4 clear ignored in level mode", pending, 9'h004);
      stat_flags = 3'b000; tick();
      chk("R4 level follows flag low", pending, 9'h000);
      lvl_mode = 3'b000; tick();
      chk("R4 back to edge mode quiet", pending, 9'h000);
   endtask

   task automatic t_dma();
      dma_active = 4'b0010; tick();
      chk("R5 rising busy ignored", pending, 9'h000);
      dma_active = 4'b0000; tick();
      chk("R5 TX B done sets bit4", pending, 9'h010);
      dma_active = 4'b1000; tick();
      dma_active = 4'b0000; tick();
      chk("R5 RX B done sets bit6", pending, 9'h050);
      pend_clr = 9'h050; tick(); pend_clr = '0;
      chk("R7 clear dma bits", pending, 9'h000);
   endtask

   task automatic t_err();
      err_pulse = 2'b01; tick(); err_pulse = '0;
      chk("R6 overrun sets bit7", pending, 9'h080);
      tick();
      chk("R6 overrun sticky", pending, 9'h080);
      err_pulse = 2'b10; pend_clr = 9'h180; tick(); err_pulse = '0; pend_clr = '0;
      chk("R8 underrun set wins over clear", pending, 9'h100);
      pend_clr = 9'h100; tick(); pend_clr = '0;
      chk("R7 clear underrun", pending, 9'h000);
   endtask

   task automatic t_enable();
      int_enable = '0;
      err_pulse = 2'b01; tick(); err_pulse = '0;
      chk("R9 recorded while disabled", pending, 9'h080);
      chk("R9 irq low while disabled", {8'h0, irq}, 9'h000);
      int_enable = 9'h080; #2;
      chk("R9 enable raises irq at once", {8'h0, irq}, 9'h001);
      top_enable = 1'b0; #2;
      chk("R10 top enable gates irq", {8'h0, irq}, 9'h000);
      top_enable = 1'b1; #2;
      chk("R10 top enable restored", {8'h0, irq}, 9'h001);
      int_enable = 9'h07F; #2;
      chk("R9 other enables do not fire", {8'h0, irq}, 9'h000);
      int_enable = '1;
      pend_clr = 9'h080; tick(); pend_clr = '0;
      chk("R2 all clear at end", pending, 9'h000);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_edge_status();
      t_level_status();
      t_dma();
      t_err();
      t_enable();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule